// File: doc/BRIEF.md
# Triggered One-Shot Delayed Pulse Generator

The block produces a single pulse on up to two outputs each time it is triggered. A trigger clears a 16-bit up-counter and starts it. The counter advances once every one, two or four clock cycles, as the prescale code selects. The outputs go high when the count reaches the compare value. They go low again when the count reaches the period value. At that point the counter stops and waits for the next trigger. One cycle of `done_o` marks the end of the run.

Software sets the block up through a small write-only register port with three registers. The control register is at address 0: bit 0 enables the timer, bits 3:1 hold the prescale code and bits 5:4 are the per-channel output enables. The period register is at address 1 and the compare register at address 2. The timer should be disabled while it is being set up. Clearing the enable stops a run that is in progress. When any setting is illegal, the block holds `err_o` high and ignores triggers.

Top module: `oneshot_pulse_gen`

## Requirements
- R1: While reset is asserted and right after it, `pulse_o`, `done_o` and `err_o` are all low.
- R2: When the block is enabled, its settings are legal and `trig_i` is sampled high at clock edge T, the count is 0 after T. With divider D, the enabled outputs rise at edge T+compare·D and fall at edge T+period·D.
- R3: Prescale code 5 gives D=1, code 6 gives D=2 and code 7 gives D=4.
- R4: Each trigger gives exactly one run. After the period match the counter stops, and the outputs stay low until the next trigger.
- R5: `done_o` is high for exactly the one cycle after the period-match edge.
- R6: A trigger during a run restarts the count from 0. Any high output goes low at that edge, and the new pulse follows the R2 timing from the new trigger.
- R7: The settings are illegal when period < 3, period ≥ 0xFFDF, compare < 3, or the prescale code is not 5, 6 or 7. While they are illegal, `err_o` is high and triggers are ignored: no output edge and no `done_o`.
- R8: With the enable bit clear, triggers are ignored. Clearing the enable during a run ends the run one edge after the register write, with the outputs low and no `done_o`.
- R9: Output channel c is driven only when its enable bit (control bit 4+c) is set. A channel that is not enabled stays low, but `done_o` still fires.
- R10: If compare ≥ period, no output rises, and `done_o` still fires at the period match. When compare equals period, the clear wins over the set.
- R11: A trigger on the same edge as a period match takes priority. The outputs go low, `done_o` is not raised, and a new run starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Kernel clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 2 | Register address (0 control, 1 period, 2 compare) |
| cfg_wdata_i | input | 16 | Register write data |
| trig_i | input | 1 | Start (or restart) a single run |
| pulse_o | output | 2 | Per-channel pulse outputs |
| done_o | output | 1 | One-cycle end-of-run strobe |
| err_o | output | 1 | Current settings are illegal |

## Verification
Two pairs of events can fall in the same cycle. A trigger can land on the period-match edge, and a set can coincide with a clear when compare equals period. The bench provokes the first by waiting until exactly one cycle before the computed end of a run and then pulsing `trig_i`. The scoreboard then expects the outputs to drop on that edge, no `done_o`, and a fresh pulse timed from the new trigger. It provokes the second by programming compare equal to period. For that case only the `done_o` edges may appear, and any rise of `pulse_o` is reported as an unexpected event.

// File: rtl/osp_pkg.sv
package osp_pkg;
  localparam int unsigned CNT_W   = 16;
  localparam int unsigned PSC_W   = 3;
  localparam int unsigned ADDR_W  = 2;

  localparam logic [PSC_W-1:0] PSC_DIV1 = 3'd5;
  localparam logic [PSC_W-1:0] PSC_DIV2 = 3'd6;
  localparam logic [PSC_W-1:0] PSC_DIV4 = 3'd7;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_PER  = 2'd1,
    ADDR_CMP  = 2'd2
  } reg_addr_e;

  // terminal value of the prescale counter for a code
  function automatic logic [1:0] psc_last(input logic [PSC_W-1:0] code);
    case (code)
      PSC_DIV2: return 2'd1;
      PSC_DIV4: return 2'd3;
      default:  return 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/osp_regs.sv
module osp_regs
  import osp_pkg::*;
#(
  parameter int unsigned NUM_CH    = 2,
  parameter int unsigned MIN_VAL   = 3,
  parameter int unsigned PER_LIMIT = 16'hFFDF
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [CNT_W-1:0]       wdata_i,
  output logic                   en_o,
  output logic [PSC_W-1:0]       psc_o,
  output logic [NUM_CH-1:0]      oen_o,
  output logic [CNT_W-1:0]       per_o,
  output logic [CNT_W-1:0]       cmp_o,
  output logic                   legal_o
);
  localparam int unsigned PSC_LSB = 1;
  localparam int unsigned OEN_LSB = PSC_LSB + PSC_W;

  logic psc_ok, per_ok, cmp_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o  <= 1'b0;
      psc_o <= PSC_DIV1;
      oen_o <= '0;
      per_o <= CNT_W'(MIN_VAL);
      cmp_o <= CNT_W'(MIN_VAL);
    end else if (we_i) begin
      case (addr_i)
        ADDR_CTRL: begin
          en_o  <= wdata_i[0];
          psc_o <= wdata_i[PSC_LSB +: PSC_W];
          oen_o <= wdata_i[OEN_LSB +: NUM_CH];
        end
        ADDR_PER: per_o <= wdata_i;
        ADDR_CMP: cmp_o <= wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    psc_ok  = (psc_o == PSC_DIV1) || (psc_o == PSC_DIV2) || (psc_o == PSC_DIV4);
    per_ok  = (per_o >= CNT_W'(MIN_VAL)) && (per_o < CNT_W'(PER_LIMIT));
    cmp_ok  = (cmp_o >= CNT_W'(MIN_VAL));
    legal_o = psc_ok && per_ok && cmp_ok;
  end
endmodule

// File: rtl/osp_counter.sv
module osp_counter
  import osp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              legal_i,
  input  logic              trig_i,
  input  logic [PSC_W-1:0]  psc_i,
  input  logic [CNT_W-1:0]  per_i,
  input  logic [CNT_W-1:0]  cmp_i,
  output logic              run_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              start_o,
  output logic              abort_o,
  output logic              set_o,
  output logic              clr_o,
  output logic              done_o
);
  logic [1:0]       pre_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic             tick;

  always_comb begin
    start_o = trig_i && en_i && legal_i;
    abort_o = !en_i && run_o;
    tick    = run_o && (pre_q >= psc_last(psc_i));
    cnt_nxt = cnt_o + CNT_W'(1);
    // restart has priority over both matches
    set_o   = tick && (cnt_nxt == cmp_i) && !start_o;
    clr_o   = tick && (cnt_nxt == per_i) && !start_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_o  <= 1'b0;
      cnt_o  <= '0;
      pre_q  <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= clr_o;
      if (start_o) begin
        run_o <= 1'b1;
        cnt_o <= '0;
        pre_q <= '0;
      end else if (abort_o) begin
        run_o <= 1'b0;
        pre_q <= '0;
      end else if (run_o) begin
        if (tick) begin
          pre_q <= '0;
          cnt_o <= cnt_nxt;
          if (cnt_nxt == per_i) run_o <= 1'b0;
        end else begin
          pre_q <= pre_q + 2'd1;
        end
      end
    end
  end
endmodule

// File: rtl/osp_out.sv
module osp_out #(
  parameter int unsigned NUM_CH = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              abort_i,
  input  logic              set_i,
  input  logic              clr_i,
  input  logic [NUM_CH-1:0] oen_i,
  output logic              level_o,
  output logic [NUM_CH-1:0] pulse_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         level_o <= 1'b0;
    else if (start_i || abort_i || clr_i) level_o <= 1'b0;
    else if (set_i)                      level_o <= 1'b1;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign pulse_o[c] = level_o & oen_i[c];
  end
endmodule

// File: rtl/oneshot_pulse_gen.sv
module oneshot_pulse_gen
  import osp_pkg::*;
#(
  parameter int unsigned NUM_CH = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [CNT_W-1:0]  cfg_wdata_i,
  input  logic              trig_i,
  output logic [NUM_CH-1:0] pulse_o,
  output logic              done_o,
  output logic              err_o
);
  logic              en, legal, run, start, abort, set, clr, level;
  logic [PSC_W-1:0]  psc;
  logic [NUM_CH-1:0] oen;
  logic [CNT_W-1:0]  per, cmp, cnt;

  osp_regs #(.NUM_CH(NUM_CH)) i_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .addr_i  (cfg_addr_i),
    .wdata_i (cfg_wdata_i),
    .en_o    (en),
    .psc_o   (psc),
    .oen_o   (oen),
    .per_o   (per),
    .cmp_o   (cmp),
    .legal_o (legal)
  );

  osp_counter i_counter (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en),
    .legal_i (legal),
    .trig_i  (trig_i),
    .psc_i   (psc),
    .per_i   (per),
    .cmp_i   (cmp),
    .run_o   (run),
    .cnt_o   (cnt),
    .start_o (start),
    .abort_o (abort),
    .set_o   (set),
    .clr_o   (clr),
    .done_o  (done_o)
  );

  osp_out #(.NUM_CH(NUM_CH)) i_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .abort_i (abort),
    .set_i   (set),
    .clr_i   (clr),
    .oen_i   (oen),
    .level_o (level),
    .pulse_o (pulse_o)
  );

  assign err_o = ~legal;
endmodule

// File: rtl/osp_checker.sv
module osp_checker #(
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned CNT_W  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              trig_i,
  input logic              en_i,
  input logic              legal_i,
  input logic              run_i,
  input logic [CNT_W-1:0]  cnt_i,
  input logic [CNT_W-1:0]  per_i,
  input logic              level_i,
  input logic [NUM_CH-1:0] pulse_i,
  input logic              done_i
);
  p_done_one_cycle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);

  p_done_stopped_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> !run_i);

  p_done_low_out_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> (pulse_i == '0));

  p_cnt_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_i < per_i));

  p_err_ignored_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_i && !legal_i && !run_i) |=> (!run_i && !level_i));

  p_disabled_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!run_i && !level_i));

  p_restart_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_i && en_i && legal_i) |=> (run_i && cnt_i == '0 && !level_i && !done_i));
endmodule

bind oneshot_pulse_gen osp_checker #(.NUM_CH(NUM_CH), .CNT_W(osp_pkg::CNT_W)) i_osp_checker (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .trig_i  (trig_i),
  .en_i    (en),
  .legal_i (legal),
  .run_i   (run),
  .cnt_i   (cnt),
  .per_i   (per),
  .level_i (level),
  .pulse_i (pulse_o),
  .done_i  (done_o)
);

// File: tb/test_oneshot_pulse_gen.sv
`timescale 1ns/1ps
module test_oneshot_pulse_gen;
  localparam int NCH = 2;

  typedef struct {
    int             cyc;
    logic [NCH:0]   val;   // {done, pulse}
    string          req;
  } ev_t;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            we = 1'b0;
  logic [1:0]      addr = '0;
  logic [15:0]     wdata = '0;
  logic            trig = 1'b0;
  logic [NCH-1:0]  pulse;
  logic            done;
  logic            err;

  int   cyc = 0;
  int   n_chk = 0;
  int   n_err = 0;
  bit   mon_on = 1'b0;
  bit   finished = 1'b0;
  ev_t  q[$];
  logic [NCH:0] prev = '0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  oneshot_pulse_gen #(.NUM_CH(NCH)) i_oneshot_pulse_gen (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_addr_i(addr),
    .cfg_wdata_i(wdata), .trig_i(trig), .pulse_o(pulse), .done_o(done), .err_o(err)
  );

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // monitor: pops the scoreboard whenever the outputs change
  always @(negedge clk) begin
    if (mon_on) begin
      logic [NCH:0] cur;
      cur = {done, pulse};
      if (cur !== prev) begin
        if (q.size() == 0) begin
          check(1'b0, "R4", "unexpected output change", int'(cur), int'(prev));
        end else begin
          ev_t e;
          e = q.pop_front();
          check(e.cyc == cyc, e.req, "event cycle", cyc, e.cyc);
          check(e.val === cur, e.req, "event value", int'(cur), int'(e.val));
        end
      end
      prev = cur;
    end
  end

  function automatic logic [15:0] ctrl(bit en, logic [2:0] psc, logic [1:0] oen);
    return {10'd0, oen, psc, en};
  endfunction

  task automatic push(int c, logic [NCH:0] v, string req);
    ev_t e;
    e.cyc = c; e.val = v; e.req = req;
    q.push_back(e);
  endtask

  task automatic expect_run(int t0, int cmpv, int perv, int d, logic [1:0] m, string req);
    if (m != 0 && cmpv < perv) push(t0 + cmpv*d, {1'b0, m}, req);
    push(t0 + perv*d, {1'b1, 2'b00}, req);
    push(t0 + perv*d + 1, {1'b0, 2'b00}, req);
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  // call at a negedge: trigger is sampled at the next edge
  task automatic fire_now(output int t);
    trig = 1'b1;
    t = cyc + 1;
  endtask

  task automatic fire_end();
    @(negedge clk);
    trig = 1'b0;
  endtask

  task automatic wait_cyc(int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic idle_check(int n, string req);
    repeat (n) @(negedge clk);
    check(q.size() == 0, req, "pending events", q.size(), 0);
    check(pulse == '0, req, "pulse idle", int'(pulse), 0);
  endtask

  task automatic run_one(int perv, int cmpv, logic [2:0] psc, int d, logic [1:0] m, string req);
    int t0;
    wr(2'd0, ctrl(1'b0, psc, m));
    wr(2'd1, 16'(perv));
    wr(2'd2, 16'(cmpv));
    wr(2'd0, ctrl(1'b1, psc, m));
    @(negedge clk);
    fire_now(t0);
    expect_run(t0, cmpv, perv, d, m, req);
    fire_end();
    wait_cyc(t0 + perv*d + 4);
  endtask

  initial begin
    int t0, t1, w;
    repeat (3) @(negedge clk);
    check(pulse == '0, "R1", "pulse in reset", int'(pulse), 0);
    check(done == 1'b0, "R1", "done in reset", int'(done), 0);
    check(err == 1'b0, "R1", "err in reset", int'(err), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(pulse == '0 && done == 1'b0, "R1", "outputs after reset", int'({done, pulse}), 0);
    mon_on = 1'b1;

    // R2 / R3: basic timing, divide-by-1/2/4; R9 channel masks
    run_one(10, 4, 3'd5, 1, 2'b11, "R2");
    idle_check(25, "R4");
    run_one(7, 3, 3'd6, 2, 2'b01, "R3");
    run_one(6, 5, 3'd7, 4, 2'b10, "R3");
    run_one(5, 3, 3'd5, 1, 2'b00, "R9");
    run_one(9, 4, 3'd6, 2, 2'b10, "R9");

    // R10: compare at or beyond period
    run_one(5, 8, 3'd5, 1, 2'b11, "R10");
    run_one(6, 6, 3'd5, 1, 2'b11, "R10");

    // R6: retrigger in the middle of a pulse
    wr(2'd1, 16'd12); wr(2'd2, 16'd4); wr(2'd0, ctrl(1'b1, 3'd5, 2'b11));
    @(negedge clk);
    fire_now(t0);
    push(t0 + 4, 3'b011, "R6");
    fire_end();
    wait_cyc(t0 + 6);
    fire_now(t1);
    push(t1, 3'b000, "R6");
    expect_run(t1, 4, 12, 1, 2'b11, "R6");
    fire_end();
    wait_cyc(t1 + 16);

    // R11: trigger on the period-match edge
    wr(2'd1, 16'd8); wr(2'd2, 16'd3); wr(2'd0, ctrl(1'b1, 3'd5, 2'b01));
    @(negedge clk);
    fire_now(t0);
    push(t0 + 3, 3'b001, "R11");
    fire_end();
    wait_cyc(t0 + 7);
    fire_now(t1);
    check(t1 == t0 + 8, "R11", "coincident edge", t1, t0 + 8);
    push(t1, 3'b000, "R11");
    expect_run(t1, 3, 8, 1, 2'b01, "R11");
    fire_end();
    wait_cyc(t1 + 12);

    // R7: illegal settings raise err and block triggers
    wr(2'd1, 16'd2);
    check(err == 1'b1, "R7", "err period<3", int'(err), 1);
    @(negedge clk); fire_now(t0); fire_end();
    idle_check(20, "R7");
    wr(2'd1, 16'hFFDF);
    check(err == 1'b1, "R7", "err period=0xFFDF", int'(err), 1);
    @(negedge clk); fire_now(t0); fire_end();
    idle_check(10, "R7");
    wr(2'd1, 16'hFFDE);
    check(err == 1'b0, "R7", "err period=0xFFDE", int'(err), 0);
    wr(2'd1, 16'd6);
    wr(2'd2, 16'd2);
    check(err == 1'b1, "R7", "err compare<3", int'(err), 1);
    @(negedge clk); fire_now(t0); fire_end();
    idle_check(10, "R7");
    wr(2'd2, 16'd3);
    wr(2'd0, ctrl(1'b1, 3'd4, 2'b11));
    check(err == 1'b1, "R7", "err prescale code 4", int'(err), 1);
    @(negedge clk); fire_now(t0); fire_end();
    idle_check(10, "R7");
    wr(2'd0, ctrl(1'b1, 3'd5, 2'b11));
    check(err == 1'b0, "R7", "err cleared", int'(err), 0);

    // R8: disabled timer ignores triggers; clearing enable aborts a run
    wr(2'd0, ctrl(1'b0, 3'd5, 2'b11));
    @(negedge clk); fire_now(t0); fire_end();
    idle_check(15, "R8");
    wr(2'd1, 16'd30); wr(2'd2, 16'd4); wr(2'd0, ctrl(1'b1, 3'd5, 2'b11));
    @(negedge clk);
    fire_now(t0);
    push(t0 + 4, 3'b011, "R8");
    fire_end();
    wait_cyc(t0 + 8);
    we = 1'b1; addr = 2'd0; wdata = ctrl(1'b0, 3'd5, 2'b11);
    w = cyc + 1;
    push(w + 1, 3'b000, "R8");
    @(negedge clk);
    we = 1'b0;
    idle_check(40, "R8");

    check(q.size() == 0, "R4", "missing events", q.size(), 0);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      check(1'b0, "R4", "watchdog expired", cyc, 0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule